// File: doc/BRIEF.md
# Single-Line Interrupt Sequencer

This block steers the program counter of a small 8-bit controller and owns its interrupt handling. There is one interrupt request line; merging several sources into that line happens outside. An enable flag gates the line. The instruction decoder sets the flag with an enable instruction and clears it with a disable instruction. Each cycle in which `step` is high is one instruction slot. In that slot the block either carries out the decoded flow-control operation or, when an enabled request is present, drops that operation and enters the service routine.

On entry the block pushes the address of the dropped instruction onto the shared call/return stack, so that instruction runs after the return. It jumps to the highest word of the program space and clears the enable flag. It also latches the CARRY and ZERO flags. A return-from-interrupt pops that address. A bit in the return instruction chooses whether the enable flag is set again. The return also presents the latched flags to the ALU for one cycle. The ALU and the program memory are outside the block.

Top module: `irq_sequencer`

## Requirements
- R1: While `rst` is high and after it falls: `pc` = 0, `ie` = 0, `irq_ack` = 0, `flags_load` = 0, and the stack is empty.
- R2: In a slot (`step`=1) with no interrupt taken, `op` selects the next `pc`. 0 = next (pc+1), 1 = jump (`target`), 2 = call (push pc+1, go to `target`), 3 = return (pop), 4 = return-from-interrupt (pop), 5 = enable (pc+1), 6 = disable (pc+1), 7 = next. All `pc` arithmetic wraps modulo 2^AW.
- R3: op 5 sets `ie` and op 6 clears it. While `ie` = 0, `irq_req` has no effect on `pc`, `ie` or `irq_ack`.
- R4: A slot with `irq_req`=1 and `ie`=1 discards the decoded op (a jump in that slot is not taken). `pc` becomes 2^AW-1, and `irq_ack` is high for exactly the following cycle.
- R5: The address pushed on entry is the `pc` of the discarded instruction, so the matching return resumes there.
- R6: Entry clears `ie`, so a request raised during the service routine is not taken.
- R7: Return-from-interrupt sets `ie` to `reti_ie`: 1 enables, 0 leaves interrupts disabled.
- R8: `carry_in` and `zero_in` are latched on entry. In the cycle after a return-from-interrupt, `flags_load` = 1 and `carry_out`/`zero_out` carry the latched values. At all other times `flags_load` = 0.
- R9: Calls and interrupt entries share one LIFO stack of DEPTH entries. Its pointer wraps modulo DEPTH, so nested calls inside a service routine return in reverse order.
- R10: `stk_push` is high in any slot that takes an interrupt or executes a call. `stk_pop` is high in any slot that executes a return of either kind. The two are never high together.
- R11: When `step` = 0, `pc`, `ie` and the stack hold, and a request is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Instruction slot: the decoded op is executed this cycle |
| op | input | 3 | Decoded flow-control operation (encoding in R2) |
| target | input | AW | Jump/call destination |
| reti_ie | input | 1 | Enable bit carried by return-from-interrupt |
| irq_req | input | 1 | Single interrupt request |
| carry_in | input | 1 | Current CARRY flag |
| zero_in | input | 1 | Current ZERO flag |
| pc | output | AW | Program counter (address of the pending instruction) |
| ie | output | 1 | Interrupt enable flag |
| irq_ack | output | 1 | One-cycle acknowledge of a taken interrupt |
| stk_push | output | 1 | Stack push in this slot |
| stk_pop | output | 1 | Stack pop in this slot |
| flags_load | output | 1 | Restore strobe for CARRY/ZERO |
| carry_out | output | 1 | CARRY value to restore |
| zero_out | output | 1 | ZERO value to restore |

## Verification
Directed runs cover several cases. A request is tried with the enable flag clear and then set, which separates gating from entry. A request is raised on a slot that holds a jump, which shows that the pending instruction is dropped rather than executed. A request is raised inside the service routine to show that entry clears the flag. Both values of the return enable bit are tried, with opposite flag patterns, so that a swapped CARRY/ZERO or a stale enable is exposed. Random streams then mix ops, request timing and idle slots, checking against a bench model. They reach deep stacks and pointer wrap that the directed cases do not.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   typedef enum logic [2:0] {
      OP_SEQ  = 3'd0,
      OP_JUMP = 3'd1,
      OP_CALL = 3'd2,
      OP_RET  = 3'd3,
      OP_RETI = 3'd4,
      OP_EINT = 3'd5,
      OP_DINT = 3'd6,
      OP_RSVD = 3'd7
   } seq_op_e;
endpackage

// File: rtl/ret_stack.sv
module ret_stack #(
   parameter int AW    = 10,
   parameter int DEPTH = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic          pop,
   input  logic [AW-1:0] wdata,
   output logic [AW-1:0] rdata
);
   localparam int SPW = $clog2(DEPTH);
   localparam logic [SPW-1:0] SP_ONE = 1;

   generate
      if (DEPTH < 2 || (1 << SPW) != DEPTH) begin : g_bad_depth
         $error("ret_stack: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [AW-1:0]  mem [DEPTH];
   logic [SPW-1:0] sp;
   logic [SPW-1:0] sp_top;

   assign sp_top = sp - SP_ONE;
   assign rdata  = mem[sp_top];

   always_ff @(posedge clk) begin
      if (rst) begin
         sp <= '0;
      end else if (push && !pop) begin
         mem[sp] <= wdata;
         sp      <= sp + SP_ONE;
      end else if (pop && !push) begin
         sp <= sp_top;
      end
   end

   // R9
   push_then_top_chk: assert property (@(posedge clk) disable iff (rst)
      (push && !pop) |=> (rdata == $past(wdata)));
endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl
   import irq_seq_pkg::*;
#(
   parameter bit SAVE_FLAGS = 1'b1
) (
   input  logic    clk,
   input  logic    rst,
   input  logic    step,
   input  seq_op_e op,
   input  logic    reti_ie,
   input  logic    irq_req,
   input  logic    carry_in,
   input  logic    zero_in,
   output logic    take,
   output logic    ie,
   output logic    ack,
   output logic    flags_load,
   output logic    carry_out,
   output logic    zero_out
);
   logic ie_q, ack_q;
   logic do_reti;

   assign take    = step && irq_req && ie_q;
   assign do_reti = step && !take && (op == OP_RETI);
   assign ie      = ie_q;
   assign ack     = ack_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ie_q  <= 1'b0;
         ack_q <= 1'b0;
      end else begin
         ack_q <= take;
         if (take) begin
            ie_q <= 1'b0;
         end else if (step) begin
            case (op)
               OP_EINT: ie_q <= 1'b1;
               OP_DINT: ie_q <= 1'b0;
               OP_RETI: ie_q <= reti_ie;
               default: ie_q <= ie_q;
            endcase
         end
      end
   end

   generate
      if (SAVE_FLAGS) begin : g_save
         logic sv_c, sv_z, fl_q, co_q, zo_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               sv_c <= 1'b0;
               sv_z <= 1'b0;
               fl_q <= 1'b0;
               co_q <= 1'b0;
               zo_q <= 1'b0;
            end else begin
               fl_q <= do_reti;
               if (take) begin
                  sv_c <= carry_in;
                  sv_z <= zero_in;
               end
               if (do_reti) begin
                  co_q <= sv_c;
                  zo_q <= sv_z;
               end
            end
         end
         assign flags_load = fl_q;
         assign carry_out  = co_q;
         assign zero_out   = zo_q;
      end else begin : g_nosave
         assign flags_load = 1'b0;
         assign carry_out  = 1'b0;
         assign zero_out   = 1'b0;
      end
   endgenerate

   // R8
   restore_cause_chk: assert property (@(posedge clk) disable iff (rst)
      flags_load |-> $past(step && op == OP_RETI && !(irq_req && ie)));
   // R3
   gated_req_chk: assert property (@(posedge clk) disable iff (rst)
      (!ie && step && irq_req) |=> !ack);
endmodule

// File: rtl/pc_steer.sv
module pc_steer
   import irq_seq_pkg::*;
#(
   parameter int AW = 10
) (
   input  logic          step,
   input  logic          take,
   input  seq_op_e       op,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] target,
   input  logic [AW-1:0] stk_top,
   output logic [AW-1:0] pc_nxt,
   output logic          push,
   output logic          pop,
   output logic [AW-1:0] push_data
);
   localparam logic [AW-1:0] VECTOR = '1;
   localparam logic [AW-1:0] PC_ONE = 1;

   logic [AW-1:0] pc_inc;
   assign pc_inc = pc + PC_ONE;

   always_comb begin
      pc_nxt    = pc;
      push      = 1'b0;
      pop       = 1'b0;
      push_data = pc_inc;
      if (step) begin
         if (take) begin
            pc_nxt    = VECTOR;
            push      = 1'b1;
            push_data = pc;
         end else begin
            case (op)
               OP_JUMP: pc_nxt = target;
               OP_CALL: begin
                  pc_nxt = target;
                  push   = 1'b1;
               end
               OP_RET, OP_RETI: begin
                  pc_nxt = stk_top;
                  pop    = 1'b1;
               end
               default: pc_nxt = pc_inc;
            endcase
         end
      end
   end
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
   import irq_seq_pkg::*;
#(
   parameter int AW         = 10,
   parameter int DEPTH      = 32,
   parameter bit SAVE_FLAGS = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step,
   input  logic [2:0]    op,
   input  logic [AW-1:0] target,
   input  logic          reti_ie,
   input  logic          irq_req,
   input  logic          carry_in,
   input  logic          zero_in,
   output logic [AW-1:0] pc,
   output logic          ie,
   output logic          irq_ack,
   output logic          stk_push,
   output logic          stk_pop,
   output logic          flags_load,
   output logic          carry_out,
   output logic          zero_out
);
   localparam logic [AW-1:0] VECTOR = '1;

   generate
      if (AW < 4 || AW > 16) begin : g_bad_aw
         $error("irq_sequencer: AW must lie in 4..16");
      end
   endgenerate

   seq_op_e       op_e;
   logic          take;
   logic [AW-1:0] pc_q, pc_nxt, stk_top, push_data;

   assign op_e = seq_op_e'(op);
   assign pc   = pc_q;

   irq_enable_ctl #(.SAVE_FLAGS(SAVE_FLAGS)) u_ie (
      .clk(clk), .rst(rst), .step(step), .op(op_e), .reti_ie(reti_ie),
      .irq_req(irq_req), .carry_in(carry_in), .zero_in(zero_in),
      .take(take), .ie(ie), .ack(irq_ack), .flags_load(flags_load),
      .carry_out(carry_out), .zero_out(zero_out)
   );

   pc_steer #(.AW(AW)) u_steer (
      .step(step), .take(take), .op(op_e), .pc(pc_q), .target(target),
      .stk_top(stk_top), .pc_nxt(pc_nxt), .push(stk_push), .pop(stk_pop),
      .push_data(push_data)
   );

   ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
      .clk(clk), .rst(rst), .push(stk_push), .pop(stk_pop),
      .wdata(push_data), .rdata(stk_top)
   );

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_nxt;
   end

   // R4
   ack_at_vector_chk: assert property (@(posedge clk) disable iff (rst)
      irq_ack |-> (pc == VECTOR));
   // R6
   entry_masks_chk: assert property (@(posedge clk) disable iff (rst)
      irq_ack |-> !ie);
   // R10
   push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(stk_push && stk_pop));
   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !step |=> ($stable(pc) && $stable(ie) && !irq_ack));
endmodule

// File: tb/irq_sequencer_test.sv
module irq_sequencer_test;
   localparam int AW = 10;
   localparam int DEPTH = 32;
   localparam logic [AW-1:0] VEC = '1;

   logic clk = 1'b0, rst = 1'b1;
   logic step = 1'b0, reti_ie = 1'b0, irq_req = 1'b0, carry_in = 1'b0, zero_in = 1'b0;
   logic [2:0] op = 3'd0;
   logic [AW-1:0] target = '0;
   logic [AW-1:0] pc;
   logic ie, irq_ack, stk_push, stk_pop, flags_load, carry_out, zero_out;

   irq_sequencer #(.AW(AW), .DEPTH(DEPTH), .SAVE_FLAGS(1'b1)) uut (
      .clk(clk), .rst(rst), .step(step), .op(op), .target(target),
      .reti_ie(reti_ie), .irq_req(irq_req), .carry_in(carry_in),
      .zero_in(zero_in), .pc(pc), .ie(ie), .irq_ack(irq_ack),
      .stk_push(stk_push), .stk_pop(stk_pop), .flags_load(flags_load),
      .carry_out(carry_out), .zero_out(zero_out)
   );

   always #5 clk = ~clk;

   int vectors = 0, errors = 0;
   bit done = 0;

   logic [AW-1:0] m_pc = '0;
   logic [AW-1:0] m_stk [DEPTH];
   int m_sp = 0, m_cnt = 0;
   logic m_ie = 0, m_ack = 0, m_fl = 0, m_co = 0, m_zo = 0, m_svc = 0, m_svz = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic apply(logic st, logic [2:0] o, logic [AW-1:0] tg, logic rie,
                        logic rq, logic c, logic z);
      logic tk, ep, eo;
      @(negedge clk);
      step = st; op = o; target = tg; reti_ie = rie; irq_req = rq;
      carry_in = c; zero_in = z;
      #1;
      tk = st && rq && m_ie;
      ep = st && (tk || o == 3'd2);
      eo = st && !tk && (o == 3'd3 || o == 3'd4);
      chk("R10 push", stk_push, ep);
      chk("R10 pop", stk_pop, eo);
      m_ack = tk;
      m_fl  = 0;
      if (st) begin
         if (tk) begin
            m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % DEPTH;
            if (m_cnt < DEPTH) m_cnt++;
            m_svc = c; m_svz = z; m_pc = VEC; m_ie = 0;
         end else begin
            case (o)
               3'd1: m_pc = tg;
               3'd2: begin
                  m_stk[m_sp] = m_pc + 1'b1; m_sp = (m_sp + 1) % DEPTH;
                  if (m_cnt < DEPTH) m_cnt++;
                  m_pc = tg;
               end
               3'd3, 3'd4: begin
                  m_sp = (m_sp + DEPTH - 1) % DEPTH;
                  m_pc = m_stk[m_sp];
                  if (m_cnt > 0) m_cnt--;
                  if (o == 3'd4) begin
                     m_ie = rie; m_fl = 1; m_co = m_svc; m_zo = m_svz;
                  end
               end
               3'd5: begin m_ie = 1; m_pc = m_pc + 1'b1; end
               3'd6: begin m_ie = 0; m_pc = m_pc + 1'b1; end
               default: m_pc = m_pc + 1'b1;
            endcase
         end
      end
      @(posedge clk);
      #2;
      chk("R2/R9 pc", pc, m_pc);
      chk("R3/R7 ie", ie, m_ie);
      chk("R4 ack", irq_ack, m_ack);
      chk("R8 flags_load", flags_load, m_fl);
      if (m_fl) begin
         chk("R8 carry_out", carry_out, m_co);
         chk("R8 zero_out", zero_out, m_zo);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1 pc in reset", pc, 0);
      rst = 1'b0;
      #2;
      chk("R1 ie", ie, 0);
      chk("R1 ack", irq_ack, 0);
      chk("R1 flags_load", flags_load, 0);

      // R3: request ignored while disabled
      apply(1, 3'd0, '0, 0, 1, 0, 0);
      chk("R3 ignored pc", pc, 1);
      chk("R3 ignored ack", irq_ack, 0);
      apply(1, 3'd5, '0, 0, 0, 0, 0);
      chk("R3 enable", ie, 1);
      // R4/R5: request preempts a jump at pc 2
      apply(1, 3'd1, 10'h055, 0, 1, 1, 0);
      chk("R4 vector", pc, VEC);
      chk("R4 ack", irq_ack, 1);
      chk("R6 cleared", ie, 0);
      // R6: request inside service routine not taken
      apply(1, 3'd0, '0, 0, 1, 0, 1);
      chk("R6 no reentry", irq_ack, 0);
      chk("R4 ack one cycle", pc, 0);
      // R5/R7/R8: return with enable bit 0
      apply(1, 3'd4, '0, 0, 0, 0, 0);
      chk("R5 resume", pc, 2);
      chk("R7 stays off", ie, 0);
      chk("R8 carry", carry_out, 1);
      chk("R8 zero", zero_out, 0);
      // R11: idle slot holds
      apply(0, 3'd1, 10'h0AA, 0, 1, 0, 0);
      chk("R11 hold pc", pc, 2);
      chk("R11 no ack", irq_ack, 0);
      // R9/R7: nested call inside service, return with enable bit 1
      apply(1, 3'd5, '0, 0, 0, 0, 0);
      apply(1, 3'd1, 10'h123, 0, 1, 0, 1);
      apply(1, 3'd2, 10'h100, 0, 0, 1, 1);
      chk("R9 call", pc, 10'h100);
      apply(1, 3'd3, '0, 0, 0, 0, 0);
      chk("R9 nested ret", pc, 0);
      apply(1, 3'd4, '0, 1, 0, 1, 0);
      chk("R5 resume 2", pc, 3);
      chk("R7 re-enabled", ie, 1);
      chk("R8 zero restored", zero_out, 1);

      for (int i = 0; i < 4000; i++) begin
         logic [2:0] o;
         int r;
         r = $urandom_range(0, 99);
         if (r < 30) o = 3'd0;
         else if (r < 40) o = 3'd1;
         else if (r < 60) o = 3'd2;
         else if (r < 72) o = 3'd3;
         else if (r < 80) o = 3'd4;
         else if (r < 90) o = 3'd5;
         else if (r < 96) o = 3'd6;
         else o = 3'd7;
         if ((o == 3'd3 || o == 3'd4) && m_cnt == 0) o = 3'd0;
         apply($urandom_range(0, 99) < 85, o, AW'($urandom),
               1'($urandom), $urandom_range(0, 99) < 20,
               1'($urandom), 1'($urandom));
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule